// File: doc/BRIEF.md
# Write-protected I2C calibration memory

This block is an I2C target that presents a 64 KiB, 16-bit-addressed byte space to a bus controller. Three windows in that space are backed by storage: a 256-byte identification area at 0x8000, a 128-byte factory calibration area at 0x8100 (both read-only from the bus) and a 128-byte user calibration area at 0x7000 that the bus may rewrite, but only while a software unlock is in force. The unlock is a single key location at 0x6FFF: storing 0xD2 there opens the user area, and storing anything else closes it again. Each stored calibration record conventionally begins with the marker byte 0xAD and ends with a check byte, and the block treats both as ordinary data.

A transaction opens with START and the device byte. For a write, two address bytes (high, then low) follow and load the internal pointer, then any number of data bytes. A read either continues from the current pointer or follows a write that set the address and a repeated START. The pointer steps after every data byte in both directions. Bytes aimed at read-only, reserved or locked locations are acknowledged and dropped, and unbacked locations read as 0xFF. A side port lets the surrounding logic load any backed byte regardless of the lock.

The bus machine has the states `ST_IDLE`, `ST_DEV`, `ST_DEV_ACK`, `ST_AHI`, `ST_AHI_ACK`, `ST_ALO`, `ST_ALO_ACK`, `ST_WDATA`, `ST_WDATA_ACK`, `ST_RDATA` and `ST_RDATA_ACK`. STOP from any state leads to `ST_IDLE`, and START from any state leads to `ST_DEV`. `ST_DEV` goes to `ST_DEV_ACK` on a matching device byte and to `ST_IDLE` otherwise. `ST_DEV_ACK` goes to `ST_RDATA` for a read and to `ST_AHI` for a write. The write path then runs `ST_AHI` → `ST_AHI_ACK` → `ST_ALO` → `ST_ALO_ACK` → `ST_WDATA` ⇄ `ST_WDATA_ACK`. The read path loops `ST_RDATA` → `ST_RDATA_ACK` → `ST_RDATA` while the controller acknowledges, and `ST_RDATA_ACK` goes to `ST_IDLE` on a not-acknowledge.

Top module: `i2c_cal_mem`

## Requirements
- R1: After reset the block does not pull SDA low, and user-area writes are locked.
- R2: The block answers only a device byte whose bits 7:1 equal `DEV_ADDR` (bit 0 is 1 for read, 0 for write) by pulling SDA low in the ninth clock. Any other device byte is not acknowledged, and everything up to the next START is ignored.
- R3: After a write device byte, the next two bytes set the pointer's high byte and then its low byte. Each takes effect when it completes and is acknowledged by pulling SDA low.
- R4: Reads return the stored byte for 0x8000–0x80FF (identification), 0x8100–0x817F (factory) and 0x7000–0x707F (user). Every other address, including 0x6FFF and the reserved ranges, returns 0xFF.
- R5: Data bytes written to the identification or factory areas are acknowledged and leave the stored contents unchanged.
- R6: Data bytes written to the user area change it only while unlocked. Otherwise, and at reserved or unbacked addresses, they are acknowledged and discarded.
- R7: A data byte of 0xD2 written at 0x6FFF unlocks the user area, and any other value written there locks it.
- R8: The pointer advances by one after every data byte, read or written. A read that starts directly after START returns data from the current pointer.
- R9: Read data is sent MSB first and changes only while SCL is low. A controller acknowledge (SDA low) requests the next byte, and a not-acknowledge leaves SDA released.
- R10: STOP returns the block to idle with SDA released, keeping any address byte already completed.
- R11: The initialisation port writes any backed byte whatever the lock state, and has no effect at unbacked addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain enable) |
| init_we | input | 1 | Initialisation write strobe |
| init_addr | input | 16 | Initialisation byte address (bus address space) |
| init_data | input | 8 | Initialisation byte value |

## Verification
The bench keeps the default window bases and sizes, the 0x6FFF key address, the 0xD2 key and two synchroniser stages, and overrides only the device address to 0x2C. With these values a few short transfers reach every window edge: 0x80FF to 0x8100, 0x817F into the reserved range, and 0x707F into 0x7080. Because 0x6FFF is directly followed by 0x7000, one sequential write can unlock the area and fill it in the same transfer. A behavioural model of the byte space and the lock predicts every acknowledge and every read byte.

// File: rtl/cal_mem_pkg.sv
package cal_mem_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEV,
        ST_DEV_ACK,
        ST_AHI,
        ST_AHI_ACK,
        ST_ALO,
        ST_ALO_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RDATA_ACK
    } bus_state_t;

endpackage

// File: rtl/cal_line_sync.sv
module cal_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              scl_q;
    logic              sda_q;

    // idle bus is high, so every stage resets to 1 and no false edge appears
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_q    <= 1'b1;
            sda_q    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
            scl_q    <= scl_pipe[STAGES-1];
            sda_q    <= sda_pipe[STAGES-1];
        end
    end

    assign scl_s     = scl_pipe[STAGES-1];
    assign sda_s     = sda_pipe[STAGES-1];
    assign scl_rise  = scl_s & ~scl_q;
    assign scl_fall  = ~scl_s & scl_q;
    assign start_det = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/cal_addr_map.sv
module cal_addr_map #(
    parameter int DESC_BASE = 32'h8000,
    parameter int DESC_LEN  = 256,
    parameter int FACT_BASE = 32'h8100,
    parameter int FACT_LEN  = 128,
    parameter int USER_BASE = 32'h7000,
    parameter int USER_LEN  = 128,
    parameter int IDX_W     = 9
) (
    input  logic [15:0]      addr,
    output logic             hit,
    output logic             writable,
    output logic [IDX_W-1:0] idx
);
    localparam int NREG = 3;
    localparam int BASE [NREG] = '{DESC_BASE, FACT_BASE, USER_BASE};
    localparam int LEN  [NREG] = '{DESC_LEN, FACT_LEN, USER_LEN};
    localparam int OFFS [NREG] = '{0, DESC_LEN, DESC_LEN + FACT_LEN};

    int a_v;

    // windows are packed back to back into one flat storage index
    always_comb begin
        a_v      = int'(addr);
        hit      = 1'b0;
        writable = 1'b0;
        idx      = '0;
        for (int r = 0; r < NREG; r++) begin
            if (a_v >= BASE[r] && a_v < BASE[r] + LEN[r]) begin
                hit      = 1'b1;
                writable = (r == NREG - 1);
                idx      = IDX_W'(a_v - BASE[r] + OFFS[r]);
            end
        end
    end

endmodule

// File: rtl/cal_store.sv
module cal_store #(
    parameter int         TOTAL      = 512,
    parameter int         IDX_W      = 9,
    parameter logic [7:0] UNLOCK_KEY = 8'hD2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             init_we,
    input  logic             init_hit,
    input  logic [IDX_W-1:0] init_idx,
    input  logic [7:0]       init_data,
    input  logic             bus_we,
    input  logic             bus_hit,
    input  logic             bus_writable,
    input  logic             bus_is_key,
    input  logic [IDX_W-1:0] bus_idx,
    input  logic [7:0]       bus_data,
    output logic [7:0]       rd_data,
    output logic             unlocked
);
    logic [7:0] mem [TOTAL];

    // initialisation port wins over a bus write in the same cycle
    always_ff @(posedge clk) begin
        if (init_we && init_hit) begin
            mem[init_idx] <= init_data;
        end else if (bus_we && bus_hit && bus_writable && unlocked) begin
            mem[bus_idx] <= bus_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            unlocked <= 1'b0;
        end else if (bus_we && bus_is_key) begin
            unlocked <= (bus_data == UNLOCK_KEY);
        end
    end

    assign rd_data = bus_hit ? mem[bus_idx] : 8'hFF;

    // R1: lock is closed when reset is released
    p_locked_at_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !unlocked);

    // R5 and R6: a bus write that is not permitted leaves the byte unchanged
    p_denied_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && !(bus_hit && bus_writable && unlocked) && !(init_we && init_hit))
        |=> (mem[$past(bus_idx)] == $past(mem[bus_idx])));

    p_key_sets_lock_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_is_key) |=> (unlocked == ($past(bus_data) == UNLOCK_KEY)));

endmodule

// File: rtl/i2c_cal_mem.sv
module i2c_cal_mem
    import cal_mem_pkg::*;
#(
    parameter logic [6:0]  DEV_ADDR    = 7'h2C,
    parameter int          DESC_BASE   = 32'h8000,
    parameter int          DESC_LEN    = 256,
    parameter int          FACT_BASE   = 32'h8100,
    parameter int          FACT_LEN    = 128,
    parameter int          USER_BASE   = 32'h7000,
    parameter int          USER_LEN    = 128,
    parameter logic [15:0] UNLOCK_ADDR = 16'h6FFF,
    parameter logic [7:0]  UNLOCK_KEY  = 8'hD2,
    parameter int          SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        scl_i,
    input  logic        sda_i,
    output logic        sda_oe,
    input  logic        init_we,
    input  logic [15:0] init_addr,
    input  logic [7:0]  init_data
);
    localparam int TOTAL = DESC_LEN + FACT_LEN + USER_LEN;
    localparam int IDX_W = $clog2(TOTAL);

    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

    bus_state_t state, nxt;
    logic [7:0]  shreg;
    logic [7:0]  rd_sh;
    logic [3:0]  bitcnt;
    logic [15:0] ptr;
    logic        rnw;
    logic        nack;
    logic        byte_end;
    logic        bus_we;

    logic             p_hit, p_wr, i_hit, i_wr;
    logic [IDX_W-1:0] p_idx, i_idx;
    logic [7:0]       rd_byte;
    logic             unlocked;

    cal_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    cal_addr_map #(
        .DESC_BASE(DESC_BASE), .DESC_LEN(DESC_LEN), .FACT_BASE(FACT_BASE),
        .FACT_LEN(FACT_LEN), .USER_BASE(USER_BASE), .USER_LEN(USER_LEN), .IDX_W(IDX_W)
    ) u_map_ptr (
        .addr(ptr), .hit(p_hit), .writable(p_wr), .idx(p_idx)
    );

    cal_addr_map #(
        .DESC_BASE(DESC_BASE), .DESC_LEN(DESC_LEN), .FACT_BASE(FACT_BASE),
        .FACT_LEN(FACT_LEN), .USER_BASE(USER_BASE), .USER_LEN(USER_LEN), .IDX_W(IDX_W)
    ) u_map_init (
        .addr(init_addr), .hit(i_hit), .writable(i_wr), .idx(i_idx)
    );

    cal_store #(.TOTAL(TOTAL), .IDX_W(IDX_W), .UNLOCK_KEY(UNLOCK_KEY)) u_store (
        .clk(clk), .rst_n(rst_n),
        .init_we(init_we), .init_hit(i_hit), .init_idx(i_idx), .init_data(init_data),
        .bus_we(bus_we), .bus_hit(p_hit), .bus_writable(p_wr),
        .bus_is_key(ptr == UNLOCK_ADDR), .bus_idx(p_idx), .bus_data(shreg),
        .rd_data(rd_byte), .unlocked(unlocked)
    );

    assign byte_end = scl_fall && (bitcnt == 4'd8);
    assign bus_we   = (state == ST_WDATA) && byte_end && !start_det && !stop_det;

    // next-state decision
    always_comb begin
        nxt = state;
        if (stop_det) begin
            nxt = ST_IDLE;
        end else if (start_det) begin
            nxt = ST_DEV;
        end else begin
            unique case (state)
                ST_IDLE:      nxt = ST_IDLE;
                ST_DEV:       if (byte_end) nxt = (shreg[7:1] == DEV_ADDR) ? ST_DEV_ACK : ST_IDLE;
                ST_DEV_ACK:   if (scl_fall) nxt = rnw ? ST_RDATA : ST_AHI;
                ST_AHI:       if (byte_end) nxt = ST_AHI_ACK;
                ST_AHI_ACK:   if (scl_fall) nxt = ST_ALO;
                ST_ALO:       if (byte_end) nxt = ST_ALO_ACK;
                ST_ALO_ACK:   if (scl_fall) nxt = ST_WDATA;
                ST_WDATA:     if (byte_end) nxt = ST_WDATA_ACK;
                ST_WDATA_ACK: if (scl_fall) nxt = ST_WDATA;
                ST_RDATA:     if (byte_end) nxt = ST_RDATA_ACK;
                ST_RDATA_ACK: if (scl_fall) nxt = nack ? ST_IDLE : ST_RDATA;
                default:      nxt = ST_IDLE;
            endcase
        end
    end

    // state register and byte datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            shreg  <= '0;
            rd_sh  <= 8'hFF;
            bitcnt <= '0;
            ptr    <= '0;
            rnw    <= 1'b0;
            nack   <= 1'b0;
        end else begin
            state <= nxt;
            if (start_det || stop_det) begin
                bitcnt <= '0;
            end else begin
                unique case (state)
                    ST_DEV, ST_AHI, ST_ALO, ST_WDATA: begin
                        if (scl_rise && bitcnt != 4'd8) begin
                            shreg  <= {shreg[6:0], sda_s};
                            bitcnt <= bitcnt + 4'd1;
                        end
                        if (byte_end) begin
                            bitcnt <= '0;
                            if (state == ST_DEV)   rnw       <= shreg[0];
                            if (state == ST_AHI)   ptr[15:8] <= shreg;
                            if (state == ST_ALO)   ptr[7:0]  <= shreg;
                            if (state == ST_WDATA) ptr       <= ptr + 16'd1;
                        end
                    end
                    ST_DEV_ACK: begin
                        if (scl_fall && rnw) begin
                            rd_sh <= rd_byte;
                            ptr   <= ptr + 16'd1;
                        end
                    end
                    ST_RDATA: begin
                        if (scl_rise) bitcnt <= bitcnt + 4'd1;
                        if (scl_fall) begin
                            if (bitcnt == 4'd8) bitcnt <= '0;
                            else                rd_sh  <= {rd_sh[6:0], 1'b1};
                        end
                    end
                    ST_RDATA_ACK: begin
                        if (scl_rise) nack <= sda_s;
                        if (scl_fall && !nack) begin
                            rd_sh <= rd_byte;
                            ptr   <= ptr + 16'd1;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // line drive
    always_comb begin
        unique case (state)
            ST_DEV_ACK, ST_AHI_ACK, ST_ALO_ACK, ST_WDATA_ACK: sda_oe = 1'b1;
            ST_RDATA: sda_oe = ~rd_sh[7];
            default:  sda_oe = 1'b0;
        endcase
    end

    p_ptr_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        bus_we |=> (ptr == $past(ptr) + 16'd1));

    p_sda_change_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe != $past(sda_oe)) |-> !scl_s);

    p_release_stop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_oe);

endmodule

// File: tb/test_i2c_cal_mem.sv
module test_i2c_cal_mem;
    localparam logic [6:0] DEV = 7'h2C;
    localparam int         Q   = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl = 1'b1;
    logic        m_sda = 1'b1;
    logic        sda_oe;
    logic        sda_line;
    logic        init_we = 1'b0;
    logic [15:0] init_addr = '0;
    logic [7:0]  init_data = '0;

    assign sda_line = m_sda & ~sda_oe;
    always #4 clk = ~clk;

    i2c_cal_mem #(.DEV_ADDR(DEV)) i_i2c_cal_mem (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe(sda_oe),
        .init_we(init_we), .init_addr(init_addr), .init_data(init_data)
    );

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [7:0]  model [int];
    bit          m_unlocked = 1'b0;
    logic [15:0] m_ptr = '0;
    logic [7:0]  wq [$];

    function automatic bit backed(input logic [15:0] a);
        return ((a >= 16'h8000) && (a <= 16'h817F)) || ((a >= 16'h7000) && (a <= 16'h707F));
    endfunction

    function automatic logic [7:0] m_read(input logic [15:0] a);
        if (backed(a)) return model[int'(a)];
        return 8'hFF;
    endfunction

    function automatic void m_write(input logic [7:0] d);
        if (m_ptr == 16'h6FFF) m_unlocked = (d == 8'hD2);
        else if (m_ptr >= 16'h7000 && m_ptr <= 16'h707F && m_unlocked) model[int'(m_ptr)] = d;
        m_ptr = m_ptr + 16'd1;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic init_one(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        init_we = 1'b1; init_addr = a; init_data = d;
        @(negedge clk);
        init_we = 1'b0;
        if (backed(a)) model[int'(a)] = d;
    endtask

    task automatic bus_start();
        m_sda = 1'b1; tick(Q); scl = 1'b1; tick(Q);
        m_sda = 1'b0; tick(Q); scl = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; tick(Q); scl = 1'b1; tick(Q); m_sda = 1'b1; tick(Q);
    endtask

    task automatic put_byte(input logic [7:0] b, output bit acked);
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i]; tick(Q); scl = 1'b1; tick(Q); scl = 1'b0; tick(Q);
        end
        m_sda = 1'b1; tick(Q); scl = 1'b1; tick(Q);
        acked = !sda_line;
        scl = 1'b0; tick(Q);
    endtask

    task automatic get_byte(input bit give_ack, output logic [7:0] b);
        m_sda = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            tick(Q); scl = 1'b1; tick(Q); b[i] = sda_line; scl = 1'b0;
        end
        tick(Q);
        m_sda = give_ack ? 1'b0 : 1'b1;
        tick(Q); scl = 1'b1; tick(Q); scl = 1'b0; tick(Q);
        m_sda = 1'b1;
    endtask

    task automatic set_addr(input logic [15:0] a);
        bit ak;
        bus_start();
        put_byte({DEV, 1'b0}, ak); chk("R3 device byte ack", int'(ak), 1);
        put_byte(a[15:8], ak);     chk("R3 high address ack", int'(ak), 1);
        put_byte(a[7:0], ak);      chk("R3 low address ack", int'(ak), 1);
        m_ptr = a;
    endtask

    task automatic rd_cur(input int n, input string tag);
        bit ak;
        logic [7:0] b;
        bus_start();
        put_byte({DEV, 1'b1}, ak); chk("R2 read device byte ack", int'(ak), 1);
        for (int i = 0; i < n; i++) begin
            get_byte(i != n - 1, b);
            chk(tag, int'(b), int'(m_read(m_ptr)));
            m_ptr = m_ptr + 16'd1;
        end
        chk("R9 line released after not-acknowledge", int'(sda_oe), 0);
        bus_stop();
    endtask

    task automatic rd_seq(input logic [15:0] a, input int n, input string tag);
        set_addr(a);
        rd_cur(n, tag);
    endtask

    task automatic wr_seq(input logic [15:0] a, input string tag);
        bit ak;
        set_addr(a);
        foreach (wq[i]) begin
            put_byte(wq[i], ak);
            chk(tag, int'(ak), 1);
            m_write(wq[i]);
        end
        bus_stop();
    endtask

    initial begin
        bit ak;
        tick(5);
        rst_n = 1'b1;
        tick(3);
        chk("R1 line released after reset", int'(sda_oe), 0);

        for (int a = 32'h8000; a <= 32'h817F; a++)
            init_one(16'(a), (a == 32'h8100) ? 8'hAD : 8'((a * 13 + 7) & 255));
        for (int a = 32'h7000; a <= 32'h707F; a++)
            init_one(16'(a), (a == 32'h7000) ? 8'hAD : 8'((a * 29 + 3) & 255));

        rd_seq(16'h8000, 4, "R4 R9 identification read");
        rd_seq(16'h80FE, 4, "R4 R8 identification into factory");
        rd_seq(16'h817E, 3, "R4 factory end into reserved");
        rd_seq(16'h707E, 3, "R4 user end into reserved");
        rd_seq(16'h6FFF, 1, "R4 key address reads blank");
        rd_seq(16'h1234, 2, "R4 unbacked address");
        rd_cur(2, "R8 current-address read");

        wq = '{8'h5A, 8'hA5};
        wr_seq(16'h8010, "R5 identification write acknowledged");
        rd_seq(16'h8010, 2, "R5 identification unchanged");
        wq = '{8'h00};
        wr_seq(16'h8100, "R5 factory write acknowledged");
        rd_seq(16'h8100, 1, "R5 factory marker kept");

        wq = '{8'h77, 8'h88};
        wr_seq(16'h7004, "R1 R6 locked user write acknowledged");
        rd_seq(16'h7004, 2, "R1 R6 user unchanged while locked");

        wq = '{8'hD2, 8'h55, 8'h66};
        wr_seq(16'h6FFF, "R7 R8 unlock then sequential write");
        rd_seq(16'h7000, 2, "R7 R6 user written after unlock");
        wq = '{8'h11, 8'h22, 8'h33};
        wr_seq(16'h707E, "R6 write across user end");
        rd_seq(16'h707E, 3, "R6 R8 user end and reserved");

        wq = '{8'hD3};
        wr_seq(16'h6FFF, "R7 relock write");
        wq = '{8'h99};
        wr_seq(16'h7010, "R7 write after relock acknowledged");
        rd_seq(16'h7010, 1, "R7 user unchanged after relock");

        bus_start();
        put_byte({7'h11, 1'b0}, ak); chk("R2 foreign device byte not acknowledged", int'(ak), 0);
        put_byte(8'h70, ak);         chk("R2 bytes ignored after foreign address", int'(ak), 0);
        bus_stop();
        rd_cur(1, "R2 pointer kept after foreign access");

        bus_start();
        put_byte({DEV, 1'b0}, ak); chk("R10 device byte ack", int'(ak), 1);
        put_byte(8'h81, ak);       chk("R10 high address ack", int'(ak), 1);
        bus_stop();
        chk("R10 line released after STOP", int'(sda_oe), 0);
        m_ptr[15:8] = 8'h81;
        rd_cur(2, "R10 R3 completed high byte kept across STOP");

        init_one(16'h7030, 8'h3C);
        init_one(16'h9000, 8'h12);
        rd_seq(16'h7030, 1, "R11 init writes user area while locked");
        rd_seq(16'h9000, 1, "R11 init ignored at unbacked address");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule